// File: doc/BRIEF.md
# Running-Disparity Balanced Lane Encoder

This block is the transmit-side coder for a three-lane parallel-to-serial link that must stay free of a DC component, so that it can run through series coupling capacitors. Once per frame it captures one 7-bit group for each data lane. Each lane keeps a signed running sum of everything it has sent, counting a 1 as +1 and a 0 as -1. The sign of that sum at the frame boundary decides whether the group is sent as it is or with every bit inverted. Two complementary marker bits go in front of the group, so the receiver can undo the inversion. Each lane therefore emits 9 serial bits per frame, one per clock.

A fourth output carries a framing clock pattern. In each frame it is high for the first few bit times and low for the rest. The high time alternates between 4 and 5 bit times on successive frames, so the pattern also balances over every pair of frames. The `grp_take` output tells the feeding logic that `grp_in` is captured at the next rising edge. The asynchronous reset is released through a two-stage synchroniser.

Top module: `dcb_encoder`

## Requirements
- R1: A frame is 9 clocks long. `grp_in` is captured at the rising edge that ends a cycle in which `grp_take` is 1. For lane l the group is bits [7l+6:7l]. In the 9 cycles that follow, lane l sends: the marker bit, its complement, and then the sent group from bit 6 down to bit 0.
- R2: The second serial bit of every frame is the complement of the first.
- R3: When a lane's running sum is zero at the frame boundary, the group is sent as it is, and the first marker bit is 0.
- R4: When the running sum is nonzero and has the same sign as the group's disparity (2·ones − 7), the group is sent inverted and the first marker bit is 1. In every other case the group is sent as it is.
- R5: At each frame boundary, a lane's running sum equals the sum of +1/−1 over every bit that lane has sent since reset, marker bits included.
- R6: Counted bit by bit from the first frame, the running sum of each data lane stays within ±10.
- R7: The clock output is high for the first 4 bits of the first frame after reset and low for the other 5. In the next frame it is high for 5 bits and low for 4, and the two alternate from then on.
- R8: Counted bit by bit, the running sum of the clock output stays within ±5.
- R9: While reset is asserted, and before the first frame, all serial outputs and `grp_take` are 0. `grp_take` first rises within 3 clocks after reset is released.
- R10: Each lane's coding depends only on its own group and history; different content on the other lanes has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_in | input | 21 | Three 7-bit groups, lane l in bits [7l+6:7l] |
| grp_take | output | 1 | grp_in is captured at the coming rising edge |
| ser_out | output | 3 | Serial bit of each data lane |
| fclk_out | output | 1 | Framing clock pattern |

## Verification
A group presented in a cycle where `grp_take` is high produces its first marker bit in the very next cycle. The remaining eight bits follow on consecutive cycles, so the last bit of a frame is on the wire in the same cycle as the next `grp_take`. The bench samples every output half a cycle after the edge. In each `grp_take` cycle it pushes a model-computed 9-bit sequence per lane, plus the clock pattern, into queues, and from the next cycle on it pops one expected bit per lane per cycle. Before the new frame is pushed, it compares the bit-level running sums it accumulated from the actual outputs with the model's boundary sums.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  // which high time the framing clock uses in the current frame
  typedef enum logic {
    PH_SHORT = 1'b0,
    PH_LONG  = 1'b1
  } clk_phase_e;
endpackage

// File: rtl/dcb_frame_timer.sv
module dcb_frame_timer #(
  parameter int FRAME = 9,
  parameter int IW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [IW-1:0] bit_idx,
  output logic          at_start
);
  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    if (idx_q == IW'(FRAME - 1)) idx_d = '0;
    else                         idx_d = idx_q + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign bit_idx  = idx_q;
  assign at_start = (idx_q == '0);

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == IW'(FRAME - 1)) |=> at_start); // R1
endmodule

// File: rtl/dcb_lane_enc.sv
module dcb_lane_enc #(
  parameter int GRP     = 7,
  parameter int IW      = 4,
  parameter int RSW     = 5,
  parameter int DSV_MAX = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic [IW-1:0]  bit_idx,
  input  logic [GRP-1:0] grp,
  output logic           ser
);
  localparam int FRAME = GRP + 2;
  localparam logic signed [RSW-1:0] STEP = RSW'(1);

  logic [FRAME-1:0]       sh_q, sh_d;
  logic signed [RSW-1:0]  rs_q, rs_d;
  logic signed [RSW-1:0]  disp;
  logic                   inv;
  int                     ones_i;
  // bit-level sum of the sent stream, kept for the bound checks
  logic signed [RSW-1:0]  mon_q, mon_d;
  logic                   mon_on_q;

  always_comb begin
    ones_i = 0;
    for (int k = 0; k < GRP; k++) ones_i = ones_i + int'(grp[k]);
    disp = RSW'(2 * ones_i - GRP);
    inv  = (rs_q != '0) && (disp != '0) && (rs_q[RSW-1] == disp[RSW-1]);
  end

  always_comb begin
    sh_d = {sh_q[FRAME-2:0], 1'b0};
    rs_d = rs_q;
    if (take) begin
      sh_d = {inv, ~inv, grp ^ {GRP{inv}}};
      rs_d = inv ? (rs_q - disp) : (rs_q + disp);
    end
  end

  always_comb begin
    mon_d = mon_q;
    if (mon_on_q) mon_d = ser ? (mon_q + STEP) : (mon_q - STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      rs_q     <= '0;
      mon_q    <= '0;
      mon_on_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      rs_q  <= rs_d;
      mon_q <= mon_d;
      if (take) mon_on_q <= 1'b1;
    end
  end

  assign ser = sh_q[FRAME-1];

  AST_FLAG_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_idx == IW'(2)) |-> (ser != $past(ser))); // R2
  AST_ZERO_SUM_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && rs_q == '0) |=> !ser); // R3
  AST_SAME_SIGN_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (take && rs_q != '0) |=> (ser == ($past(rs_q[RSW-1]) == $past(disp[RSW-1])))); // R4
  AST_SUM_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_on_q && bit_idx == IW'(1)) |-> (mon_q == $past(rs_q))); // R5
  AST_DATA_DSV: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_q <= DSV_MAX) && (mon_q >= -DSV_MAX)); // R6
endmodule

// File: rtl/dcb_clk_lane.sv
module dcb_clk_lane
  import dcb_pkg::*;
#(
  parameter int FRAME = 9,
  parameter int IW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [IW-1:0] bit_idx,
  output logic          fclk
);
  localparam int HI_S = FRAME / 2;
  localparam int HI_L = FRAME - HI_S;
  localparam int CSW  = $clog2(FRAME + 1) + 1;
  localparam logic signed [CSW-1:0] STEP = CSW'(1);

  clk_phase_e            ph_q, ph_d;
  logic [FRAME-1:0]      sh_q, sh_d, pat;
  int                    hi;
  logic signed [CSW-1:0] mon_q, mon_d;
  logic                  mon_on_q;
  logic [IW-1:0]         run_q, run_d, last_q, last_d;

  always_comb begin
    hi = (ph_q == PH_SHORT) ? HI_S : HI_L;
    for (int k = 0; k < FRAME; k++) pat[FRAME-1-k] = (k < hi);
  end

  always_comb begin
    sh_d = {sh_q[FRAME-2:0], 1'b0};
    ph_d = ph_q;
    if (take) begin
      sh_d = pat;
      ph_d = (ph_q == PH_SHORT) ? PH_LONG : PH_SHORT;
    end
  end

  always_comb begin
    mon_d  = mon_q;
    run_d  = run_q;
    last_d = last_q;
    if (mon_on_q) mon_d = fclk ? (mon_q + STEP) : (mon_q - STEP);
    if (fclk) begin
      run_d = run_q + IW'(1);
    end else begin
      if (run_q != '0) last_d = run_q;
      run_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      ph_q     <= PH_SHORT;
      mon_q    <= '0;
      mon_on_q <= 1'b0;
      run_q    <= '0;
      last_q   <= '0;
    end else begin
      sh_q   <= sh_d;
      ph_q   <= ph_d;
      mon_q  <= mon_d;
      run_q  <= run_d;
      last_q <= last_d;
      if (take) mon_on_q <= 1'b1;
    end
  end

  assign fclk = sh_q[FRAME-1];

  AST_CLK_LEAD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_on_q && bit_idx == IW'(1)) |-> fclk); // R7
  AST_CLK_RUN_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fclk) |-> ((run_q != last_q) &&
                     (run_q == IW'(HI_S) || run_q == IW'(HI_L)))); // R7
  AST_CLK_DSV: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_q <= HI_L) && (mon_q >= -HI_L)); // R8
endmodule

// File: rtl/dcb_encoder.sv
module dcb_encoder #(
  parameter int LANES = 3,
  parameter int GRP   = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LANES*GRP-1:0] grp_in,
  output logic                 grp_take,
  output logic [LANES-1:0]     ser_out,
  output logic                 fclk_out
);
  localparam int FRAME   = GRP + 2;
  localparam int IW      = $clog2(FRAME);
  localparam int DSV_MAX = GRP + (GRP - 1) / 2;
  localparam int RSW     = $clog2(DSV_MAX + 1) + 1;

  logic [1:0]    rsync_q;
  logic          srst_n;
  logic [IW-1:0] bit_idx;
  logic          at_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  dcb_frame_timer #(.FRAME(FRAME), .IW(IW)) u_timer (
    .clk      (clk),
    .rst_n    (srst_n),
    .bit_idx  (bit_idx),
    .at_start (at_start)
  );

  assign grp_take = at_start & srst_n;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dcb_lane_enc #(.GRP(GRP), .IW(IW), .RSW(RSW), .DSV_MAX(DSV_MAX)) u_lane (
      .clk     (clk),
      .rst_n   (srst_n),
      .take    (grp_take),
      .bit_idx (bit_idx),
      .grp     (grp_in[l*GRP +: GRP]),
      .ser     (ser_out[l])
    );
  end

  dcb_clk_lane #(.FRAME(FRAME), .IW(IW)) u_clk_lane (
    .clk     (clk),
    .rst_n   (srst_n),
    .take    (grp_take),
    .bit_idx (bit_idx),
    .fclk    (fclk_out)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !srst_n |-> (!grp_take && ser_out == '0 && !fclk_out)); // R9
endmodule

// File: tb/dcb_encoder_test.sv
module dcb_encoder_test;
  localparam int LANES = 3;
  localparam int GRP   = 7;
  localparam int FRAME = GRP + 2;
  localparam int W     = LANES * GRP;
  localparam int NFR   = 200;
  localparam int DLIM  = GRP + (GRP - 1) / 2;
  localparam int CLIM  = FRAME - FRAME / 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] grp_in = '0;
  logic         grp_take;
  logic [LANES-1:0] ser_out;
  logic         fclk_out;

  always #10 clk = ~clk;

  dcb_encoder #(.LANES(LANES), .GRP(GRP)) uut (
    .clk(clk), .rst_n(rst_n), .grp_in(grp_in),
    .grp_take(grp_take), .ser_out(ser_out), .fclk_out(fclk_out)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  bit exp_q[LANES][$];
  string tag_q[LANES][$];
  bit clk_q[$];
  int rs_m[LANES];
  int bsum[LANES];
  int csum = 0;
  bit clk_long = 0;
  int frame_no = 0;

  task automatic check(bit ok, string tag, int act, int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic logic [W-1:0] gen(int f);
    logic [W-1:0] v;
    logic [31:0]  r;
    for (int l = 0; l < LANES; l++) begin
      r = $urandom;
      if (f < 40 || f >= 140)   v[l*GRP +: GRP] = r[GRP-1:0];
      else if (f < 60)          v[l*GRP +: GRP] = '1;
      else if (f < 80)          v[l*GRP +: GRP] = '0;
      else if (f < 100)         v[l*GRP +: GRP] = (f % 2 == 1) ? '1 : '0;
      else if (f < 120)         v[l*GRP +: GRP] = (f % 2 == 0) ? 7'h7F : 7'b1110000;
      else if (l == 0)          v[l*GRP +: GRP] = '1;
      else if (l == 1)          v[l*GRP +: GRP] = '0;
      else                      v[l*GRP +: GRP] = r[GRP-1:0];
    end
    return v;
  endfunction

  task automatic push_frame(logic [W-1:0] v, int f);
    logic [GRP-1:0] g;
    int  disp;
    bit  inv;
    int  hi;
    string dtag;
    dtag = (f >= 120 && f < 140) ? "R10 lane data" : "R1 data";
    for (int l = 0; l < LANES; l++) begin
      g    = v[l*GRP +: GRP];
      disp = 2 * $countones(g) - GRP;
      inv  = (rs_m[l] != 0) && ((rs_m[l] > 0) == (disp > 0));
      exp_q[l].push_back(inv);
      tag_q[l].push_back(rs_m[l] == 0 ? "R3 marker" : "R4 marker");
      exp_q[l].push_back(!inv);
      tag_q[l].push_back("R2 marker complement");
      for (int k = GRP - 1; k >= 0; k--) begin
        exp_q[l].push_back(g[k] ^ inv);
        tag_q[l].push_back(dtag);
      end
      rs_m[l] = inv ? rs_m[l] - disp : rs_m[l] + disp;
    end
    hi = clk_long ? CLIM : FRAME / 2;
    for (int k = 0; k < FRAME; k++) clk_q.push_back(k < hi);
    clk_long = !clk_long;
  endtask

  task automatic step();
    bit e;
    string t;
    for (int l = 0; l < LANES; l++) begin
      if (exp_q[l].size() > 0) begin
        e = exp_q[l].pop_front();
        t = tag_q[l].pop_front();
        check(ser_out[l] == e, t, int'(ser_out[l]), int'(e));
        bsum[l] += ser_out[l] ? 1 : -1;
        check(bsum[l] <= DLIM && bsum[l] >= -DLIM, "R6 data lane sum", bsum[l], DLIM);
      end else begin
        check(ser_out[l] == 1'b0, "R9 idle lane", int'(ser_out[l]), 0);
      end
    end
    if (clk_q.size() > 0) begin
      e = clk_q.pop_front();
      check(fclk_out == e, "R7 clock pattern", int'(fclk_out), int'(e));
      csum += fclk_out ? 1 : -1;
      check(csum <= CLIM && csum >= -CLIM, "R8 clock sum", csum, CLIM);
    end else begin
      check(fclk_out == 1'b0, "R9 idle clock", int'(fclk_out), 0);
    end
  endtask

  initial begin
    logic [W-1:0] v;
    int wait_cyc;
    for (int l = 0; l < LANES; l++) begin rs_m[l] = 0; bsum[l] = 0; end
    repeat (2) begin
      @(negedge clk);
      check(grp_take == 1'b0, "R9 reset take", int'(grp_take), 0);
      check(ser_out == '0, "R9 reset lanes", int'(ser_out), 0);
      check(fclk_out == 1'b0, "R9 reset clock", int'(fclk_out), 0);
    end
    rst_n = 1'b1;
    wait_cyc = 0;
    while (frame_no < NFR) begin
      @(negedge clk);
      step();
      if (frame_no == 0 && !grp_take) wait_cyc++;
      if (grp_take) begin
        if (frame_no == 0) check(wait_cyc <= 3, "R9 first take", wait_cyc, 3);
        for (int l = 0; l < LANES; l++)
          check(bsum[l] == rs_m[l], "R5 boundary sum", bsum[l], rs_m[l]);
        v = gen(frame_no);
        grp_in = v;
        push_frame(v, frame_no);
        frame_no++;
      end
    end
    repeat (FRAME) begin
      @(negedge clk);
      step();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d frames expected %0d", frame_no, NFR);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule